// File: doc/BRIEF.md
# Active Video Region Detector

This block watches a pixel stream of luma samples, one per clock, framed by active-high horizontal and vertical sync pulses. It finds where the non-blank picture lies inside the raster. Its output is a horizontal start and end pixel and a vertical start and end line. It also measures the line period in clocks and the width of the horizontal sync pulse. All six results are registered and refreshed together once per frame, in the clock that follows the vertical sync leading edge. Between those edges they hold steady, so a controller can read them at any time.

Two search modes are available. In probe mode the horizontal bounds come from one chosen line, and the vertical bounds come from one chosen pixel column. Both are set in steps of eight. In whole-frame mode the bounds are the smallest and largest positions of any non-blank sample in the frame. The horizontal and vertical searches may share one luma threshold or use separate ones. Sync polarity must be normalised upstream. Configuration inputs are expected to be static within a frame.

Top module: `avd_detect`

## Requirements
- R1: A sample is non-blank for the horizontal search when `luma_i >= h_thr_i`; equality counts as non-blank, and one code below the threshold is blank.
- R2: With `split_thr_i` = 0 the vertical search also compares against `h_thr_i`; with `split_thr_i` = 1 it compares against `v_thr_i`.
- R3: Pixel positions count from 0 at the clock in which `hsync_i` rises. In probe mode (`whole_frame_i` = 0), `h_start_o`/`h_end_o` are the first and last non-blank pixel positions on line `probe_line_i`*8.
- R4: Line numbers count from 0 at the first `hsync_i` rise at or after a `vsync_i` rise. In probe mode, `v_start_o`/`v_end_o` are the first and last lines whose pixel at position `probe_col_i`*8 is non-blank. For example, a probe column code of 37h selects pixel 440, and a probe line code of 06h selects line 48.
- R5: In whole-frame mode (`whole_frame_i` = 1), the start outputs are the minimum position and the end outputs are the maximum position over every non-blank sample of the frame, including a single isolated sample (start equals end).
- R6: `h_total_o` is the number of clocks between the last two `hsync_i` rises before the `vsync_i` rise, and the rise that coincides with the `vsync_i` rise counts as one of them.
- R7: `hs_width_o` is the number of clocks `hsync_i` was high in the last completed pulse, saturating at 255.
- R8: All outputs change only in the clock after a `vsync_i` rise. The sample presented in that rising clock belongs to no frame and is not examined.
- R9: If a frame has no non-blank sample for a direction, that direction's start and end outputs keep their previous values, while `h_total_o` and `hs_width_o` still update.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| luma_i | input | 8 | Luma of the current pixel |
| h_thr_i | input | 8 | Horizontal (and shared) threshold |
| v_thr_i | input | 8 | Vertical threshold when split |
| split_thr_i | input | 1 | 1: vertical search uses v_thr_i |
| whole_frame_i | input | 1 | 1: whole-frame mode, 0: probe mode |
| probe_line_i | input | 8 | Probe line in units of 8 lines |
| probe_col_i | input | 8 | Probe column in units of 8 pixels |
| h_start_o | output | 11 | First non-blank pixel position |
| h_end_o | output | 11 | Last non-blank pixel position |
| v_start_o | output | 11 | First non-blank line |
| v_end_o | output | 11 | Last non-blank line |
| h_total_o | output | 11 | Clocks per line |
| hs_width_o | output | 8 | Horizontal sync width in clocks |

## Verification
The bench always starts each frame with `vsync_i` and `hsync_i` rising in the same clock. That clock must close the old frame and start line 0 of the new one. It must also deliver the line length of the line that ends at that same edge. The bench judges this by comparing `h_total_o` and both vertical bounds against a model in which the closing line and line 0 are counted exactly. A slip of one line or one clock in either counter shows up as an off-by-one in those results.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int unsigned N_DIR = 2;
  localparam int unsigned DIR_H = 0;
  localparam int unsigned DIR_V = 1;
endpackage

// File: rtl/avd_timing.sv
module avd_timing #(
  parameter int PIX_W = 11,
  parameter int HSW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic             hs_rise_o,
  output logic             vs_rise_o,
  output logic             line_ok_o,
  output logic [PIX_W-1:0] x_pos_o,
  output logic [PIX_W-1:0] y_pos_o,
  output logic [PIX_W-1:0] line_len_o,
  output logic [HSW_W-1:0] hs_wid_o
);
  localparam logic [PIX_W-1:0] PMAX = '1;
  localparam logic [PIX_W-1:0] YMAX = PMAX - 1'b1;
  localparam logic [HSW_W-1:0] WMAX = '1;

  logic             hs_q, vs_q, hs_fall;
  logic [PIX_W-1:0] x_q, y_q, y_nxt, len_q;
  logic [HSW_W-1:0] hw_q, hwl_q;

  assign hs_rise_o = hsync_i & ~hs_q;
  assign hs_fall   = ~hsync_i & hs_q;
  assign vs_rise_o = vsync_i & ~vs_q;
  assign x_pos_o   = hs_rise_o ? '0 : x_q;

  // y_q all ones marks "before line 0"
  always_comb begin
    y_nxt = y_q;
    if (vs_rise_o)      y_nxt = hs_rise_o ? '0 : PMAX;
    else if (hs_rise_o) y_nxt = (y_q == PMAX) ? '0 :
                                (y_q == YMAX) ? YMAX : y_q + 1'b1;
  end

  assign y_pos_o    = y_nxt;
  assign line_ok_o  = (y_nxt != PMAX);
  assign line_len_o = hs_rise_o ? x_q : len_q;
  assign hs_wid_o   = hs_fall ? hw_q : hwl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      x_q   <= '0;
      y_q   <= PMAX;
      len_q <= '0;
      hw_q  <= '0;
      hwl_q <= '0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      x_q  <= (x_pos_o == PMAX) ? PMAX : x_pos_o + 1'b1;
      y_q  <= y_nxt;
      if (hs_rise_o) len_q <= x_q;
      if (hs_rise_o)                        hw_q <= HSW_W'(1);
      else if (hsync_i && (hw_q != WMAX))   hw_q <= hw_q + 1'b1;
      if (hs_fall) hwl_q <= hw_q;
    end
  end

  AST_HSW_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_q == WMAX && hsync_i && !hs_rise_o) |=> (hw_q == WMAX)); // R7

  AST_LINE0_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise_o && hs_rise_o) |=> (y_q == '0)); // R4
endmodule

// File: rtl/avd_extent.sv
module avd_extent #(
  parameter int PIX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             hit_i,
  input  logic [PIX_W-1:0] pos_i,
  output logic [PIX_W-1:0] first_o,
  output logic [PIX_W-1:0] last_o
);
  logic             found_q;
  logic [PIX_W-1:0] lo_q, hi_q, first_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (frame_i) begin
      found_q <= 1'b0;
      if (found_q) begin
        first_q <= lo_q;
        last_q  <= hi_q;
      end
    end else if (hit_i) begin
      found_q <= 1'b1;
      lo_q    <= (!found_q || pos_i < lo_q) ? pos_i : lo_q;
      hi_q    <= (!found_q || pos_i > hi_q) ? pos_i : hi_q;
    end
  end

  assign first_o = first_q;
  assign last_o  = last_q;

  AST_EXT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> (lo_q <= hi_q)); // R5

  AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !found_q) |=> ($stable(first_o) && $stable(last_o))); // R9
endmodule

// File: rtl/avd_detect.sv
module avd_detect
  import avd_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LUMA_W = 8,
  parameter int HSW_W  = 8,
  parameter int PRB_W  = 8,
  parameter int PRB_SH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [LUMA_W-1:0] luma_i,
  input  logic [LUMA_W-1:0] h_thr_i,
  input  logic [LUMA_W-1:0] v_thr_i,
  input  logic              split_thr_i,
  input  logic              whole_frame_i,
  input  logic [PRB_W-1:0]  probe_line_i,
  input  logic [PRB_W-1:0]  probe_col_i,
  output logic [PIX_W-1:0]  h_start_o,
  output logic [PIX_W-1:0]  h_end_o,
  output logic [PIX_W-1:0]  v_start_o,
  output logic [PIX_W-1:0]  v_end_o,
  output logic [PIX_W-1:0]  h_total_o,
  output logic [HSW_W-1:0]  hs_width_o
);
  localparam int PRB_FULL = PRB_W + PRB_SH;

  logic              hs_rise, vs_rise, line_ok;
  logic [PIX_W-1:0]  x_pos, y_pos, line_len;
  logic [HSW_W-1:0]  hs_wid;
  logic [LUMA_W-1:0] v_thr_eff;
  logic [PRB_FULL-1:0] py_raw, px_raw;
  logic [PIX_W-1:0]  probe_y, probe_x;
  logic              h_act, v_act;

  logic [N_DIR-1:0]  hit;
  logic [PIX_W-1:0]  pos   [N_DIR];
  logic [PIX_W-1:0]  first [N_DIR];
  logic [PIX_W-1:0]  last  [N_DIR];

  avd_timing #(.PIX_W(PIX_W), .HSW_W(HSW_W)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .vsync_i    (vsync_i),
    .hs_rise_o  (hs_rise),
    .vs_rise_o  (vs_rise),
    .line_ok_o  (line_ok),
    .x_pos_o    (x_pos),
    .y_pos_o    (y_pos),
    .line_len_o (line_len),
    .hs_wid_o   (hs_wid)
  );

  assign v_thr_eff = split_thr_i ? v_thr_i : h_thr_i;
  assign h_act     = (luma_i >= h_thr_i);
  assign v_act     = (luma_i >= v_thr_eff);
  assign py_raw    = {probe_line_i, {PRB_SH{1'b0}}};
  assign px_raw    = {probe_col_i,  {PRB_SH{1'b0}}};
  assign probe_y   = PIX_W'(py_raw);
  assign probe_x   = PIX_W'(px_raw);

  // edge clock pixel belongs to no frame
  assign hit[DIR_H] = ~vs_rise & line_ok & h_act & (whole_frame_i | (y_pos == probe_y));
  assign hit[DIR_V] = ~vs_rise & line_ok & v_act & (whole_frame_i | (x_pos == probe_x));
  assign pos[DIR_H] = x_pos;
  assign pos[DIR_V] = y_pos;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    avd_extent #(.PIX_W(PIX_W)) u_ext (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (vs_rise),
      .hit_i   (hit[d]),
      .pos_i   (pos[d]),
      .first_o (first[d]),
      .last_o  (last[d])
    );
  end

  assign h_start_o = first[DIR_H];
  assign h_end_o   = last[DIR_H];
  assign v_start_o = first[DIR_V];
  assign v_end_o   = last[DIR_V];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_total_o  <= '0;
      hs_width_o <= '0;
    end else if (vs_rise) begin
      h_total_o  <= line_len;
      hs_width_o <= hs_wid;
    end
  end

  AST_SYNC_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise |=> ($stable(h_start_o) && $stable(h_end_o) && $stable(v_start_o) &&
                  $stable(v_end_o) && $stable(h_total_o) && $stable(hs_width_o))); // R8

  AST_PROBE_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit[DIR_H] && !whole_frame_i) |-> (y_pos == probe_y)); // R3
endmodule

// File: tb/sim_avd_detect.sv
module sim_avd_detect;
  typedef struct packed {
    int tot; int nl; int hsw;
    int ax0; int ax1; int ay0; int ay1;
    int bx0; int bx1; int by0; int by1;
    int lin; int lout; int hthr; int vthr;
    int split; int whole; int pl; int pc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R3 R4 probe mode, line 16, column 40
    '{100, 30, 8,   20, 70, 10, 25,  10, 80, 27, 28,  'h40, 'h10, 'h20, 'h20, 0, 0, 2, 5},
    // R5 same picture, whole frame
    '{100, 30, 8,   20, 70, 10, 25,  10, 80, 27, 28,  'h40, 'h10, 'h20, 'h20, 0, 1, 2, 5},
    // R1 luma equal to threshold, background one below
    '{90,  20, 12,  15, 50,  4, 12,   1,  0,  0,  0,  'h20, 'h1f, 'h20, 'h20, 0, 1, 0, 0},
    // R2 R9 split vertical threshold above picture: vertical held
    '{100, 30, 8,   20, 70, 10, 25,   1,  0,  0,  0,  'h40, 'h10, 'h20, 'h50, 1, 0, 2, 5},
    // R2 split vertical threshold below picture
    '{80,  24, 6,   30, 60,  5, 20,   1,  0,  0,  0,  'h40, 'h00, 'h20, 'h30, 1, 0, 1, 6},
    // R3 R4 R7 codes 06h/37h -> line 48, pixel 440; sync width 300 saturates
    '{500, 60, 300, 400,480, 40, 55,  1,  0,  0,  0,  'h80, 'h00, 'h20, 'h20, 0, 0, 6, 'h37},
    // R9 dark frame, widths still update; R7 exactly 255
    '{300, 8, 255,  1,  0,  0,  0,    1,  0,  0,  0,  'h10, 'h00, 'h20, 'h20, 0, 1, 0, 0},
    // R5 R1 single sample at max threshold
    '{100, 8, 5,    1,  0,  0,  0,   99, 99,  6,  6,  'hff, 'h00, 'hff, 'hff, 0, 1, 0, 0}
  };
  localparam vec_t FLUSH = '{20, 4, 3, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 'h20, 'h20, 0, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0;
  logic [7:0]  luma_i = '0, h_thr_i = '0, v_thr_i = '0;
  logic        split_thr_i = 1'b0, whole_frame_i = 1'b0;
  logic [7:0]  probe_line_i = '0, probe_col_i = '0;
  logic [10:0] h_start_o, h_end_o, v_start_o, v_end_o, h_total_o;
  logic [7:0]  hs_width_o;

  always #5 clk = ~clk;

  avd_detect u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .luma_i(luma_i), .h_thr_i(h_thr_i), .v_thr_i(v_thr_i),
    .split_thr_i(split_thr_i), .whole_frame_i(whole_frame_i),
    .probe_line_i(probe_line_i), .probe_col_i(probe_col_i),
    .h_start_o(h_start_o), .h_end_o(h_end_o), .v_start_o(v_start_o),
    .v_end_o(v_end_o), .h_total_o(h_total_o), .hs_width_o(hs_width_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit acc_hf = 0, acc_vf = 0;
  int acc_hmin, acc_hmax, acc_vmin, acc_vmax;
  int l_hs = 0, l_he = 0, l_vs = 0, l_ve = 0, l_tot = 0, l_hsw = 0;
  int p_tot = 0, p_hsw = 0, p_whole = 0, p_split = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string ht, string vt);
    chk({ht, " h_start"}, int'(h_start_o), l_hs);
    chk({ht, " h_end"},   int'(h_end_o),   l_he);
    chk({vt, " v_start"}, int'(v_start_o), l_vs);
    chk({vt, " v_end"},   int'(v_end_o),   l_ve);
    chk("R6 h_total",     int'(h_total_o), l_tot);
    chk("R7 hs_width",    int'(hs_width_o), l_hsw);
  endtask

  task automatic run_frame(input vec_t v, input bit do_chk);
    string ht, vt;
    int lum, vthr;
    bit in_r;
    ht = acc_hf ? (p_whole != 0 ? "R5" : "R3") : "R9";
    vt = acc_vf ? (p_whole != 0 ? "R5" : "R4") : "R9";
    if (p_split != 0) vt = {vt, " R2"};
    if (acc_hf) begin l_hs = acc_hmin; l_he = acc_hmax; end
    if (acc_vf) begin l_vs = acc_vmin; l_ve = acc_vmax; end
    l_tot = p_tot;
    l_hsw = p_hsw;
    acc_hf = 0;
    acc_vf = 0;
    vthr = (v.split != 0) ? v.vthr : v.hthr;
    for (int y = 0; y < v.nl; y++) begin
      for (int x = 0; x < v.tot; x++) begin
        @(negedge clk);
        if (do_chk && y == 0 && x == 1) check_all(ht, vt);
        if (do_chk && y == v.nl - 1 && x == v.tot - 1) begin
          chk("R8 mid h_start", int'(h_start_o), l_hs);
          chk("R8 mid v_end",   int'(v_end_o),   l_ve);
          chk("R8 mid h_total", int'(h_total_o), l_tot);
        end
        in_r = (x >= v.ax0 && x <= v.ax1 && y >= v.ay0 && y <= v.ay1) ||
               (x >= v.bx0 && x <= v.bx1 && y >= v.by0 && y <= v.by1);
        lum = in_r ? v.lin : v.lout;
        hsync_i       <= (x < v.hsw);
        vsync_i       <= (y < 2);
        luma_i        <= 8'(lum);
        h_thr_i       <= 8'(v.hthr);
        v_thr_i       <= 8'(v.vthr);
        split_thr_i   <= (v.split != 0);
        whole_frame_i <= (v.whole != 0);
        probe_line_i  <= 8'(v.pl);
        probe_col_i   <= 8'(v.pc);
        if (!(x == 0 && y == 0)) begin
          if (lum >= v.hthr && (v.whole != 0 || y == v.pl * 8)) begin
            acc_hmin = (!acc_hf || x < acc_hmin) ? x : acc_hmin;
            acc_hmax = (!acc_hf || x > acc_hmax) ? x : acc_hmax;
            acc_hf = 1;
          end
          if (lum >= vthr && (v.whole != 0 || x == v.pc * 8)) begin
            acc_vmin = (!acc_vf || y < acc_vmin) ? y : acc_vmin;
            acc_vmax = (!acc_vf || y > acc_vmax) ? y : acc_vmax;
            acc_vf = 1;
          end
        end
      end
    end
    p_tot = v.tot;
    p_hsw = (v.hsw > 255) ? 255 : v.hsw;
    p_whole = v.whole;
    p_split = v.split;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 h_start", int'(h_start_o), 0);
    chk("R10 h_end",   int'(h_end_o),   0);
    chk("R10 v_start", int'(v_start_o), 0);
    chk("R10 v_end",   int'(v_end_o),   0);
    chk("R10 h_total", int'(h_total_o), 0);
    chk("R10 hs_width", int'(hs_width_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_frame(VEC[i], i != 0);
    run_frame(FLUSH, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule